// File: doc/BRIEF.md
# Debug Transport Access Register Path

This block is the data-register side of a JTAG debug transport. Two scan registers sit behind instruction selection: a 32-bit control/status word and an access word that carries an operation, a 32-bit data field and an address. On capture-DR and update-DR the block loads or acts on whichever register is selected. An update of the access word becomes a read or write request to a debug module over a small request/response port. The result of that access is stored and returned on the next capture.

The block enforces a minimum number of Run-Test/Idle cycles after each accepted access. A capture of the access word before those cycles have passed, or while a request is still outstanding, returns the busy code and sets a sticky busy flag. While the flag is set, updates of the access word are dropped. Software clears the flag through the control word. A second control bit resets the whole transport state.

The TAP state machine is external and drives the capture, shift, update and idle strobes, each one clock wide. The debug module is also external.

Top module: `dmi_access_port`

## Requirements
- R1: A capture with `drSel`=1 (control) loads a 32-bit word with the version in bits 3:0, `ABITS` in bits 9:4, a status in bits 11:10 (3 while busy is sticky, 0 otherwise), the idle hint min(`MIN_IDLE`,7) in bits 14:12 and zeros elsewhere.
- R2: An update of the control word with bit 16 set clears the sticky busy flag and leaves the stored access result and the idle counter unchanged.
- R3: An update of the control word with bit 17 set clears the sticky busy flag, the idle counter and the stored result (all fields zero).
- R4: A capture with `drSel`=2 (access) loads the value 3 and sets the sticky busy flag when idle cycles are still owed, a request is outstanding, or busy is already sticky. The flag stays set until R2 or R3 clears it.
- R5: Otherwise a capture of the access word loads the stored result, laid out as op in bits 1:0, data in bits 33:2 and address in bits ABITS+33:34.
- R6: An accepted access update with op 1 (read) issues a one-cycle request with `dmReqWrite`=0 and the shifted address. The stored data field becomes the returned data when no error is reported.
- R7: An accepted access update with op 2 (write) issues a one-cycle request with `dmReqWrite`=1, the shifted address and data. The stored result keeps the shifted address and data.
- R8: The stored op field becomes 0 (success) when the response has `dmRespErr`=0 and 2 (failed) when it has `dmRespErr`=1.
- R9: Each accepted access reloads the idle counter with `MIN_IDLE`. Each `rtiTick` decrements it, and it stays at zero once there.
- R10: While busy is sticky, an access update issues no request and leaves the stored result unchanged.
- R11: Shifting moves the selected register toward `tdo`, least significant bit first, with `tdi` entering at the top bit of the selected length: 32 for control, ABITS+34 for access, 1 for bypass (`drSel` 0 or 3, which captures 0).
- R12: An accepted access update with op 0 (or op 3) issues no request and stores the shifted address and data with op 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| drSel | input | 2 | Selected data register: 0/3 bypass, 1 control, 2 access |
| captureDr | input | 1 | Capture-DR strobe |
| shiftDr | input | 1 | Shift-DR strobe, one bit per cycle |
| updateDr | input | 1 | Update-DR strobe |
| rtiTick | input | 1 | One Run-Test/Idle cycle elapsed |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out (LSB of shift register) |
| dmReqValid | output | 1 | Debug module request, one cycle |
| dmReqWrite | output | 1 | Request is a write |
| dmReqAddr | output | ABITS | Request address |
| dmReqData | output | 32 | Write data |
| dmRespValid | input | 1 | Debug module response valid |
| dmRespData | input | 32 | Read data |
| dmRespErr | input | 1 | Access failed |

## Verification
A capture lands in the shift register at the clock edge of the strobe, so its first bit is on `tdo` at the following falling edge. Each later bit appears one shift edge after the one before, and the bench samples `tdo` on falling edges just before it raises each shift. A request appears one edge after the update strobe, and the responder answers on the next cycle. The stored result is therefore updated two edges after the update. The bench always inserts at least `MIN_IDLE` idle ticks, or deliberately fewer, before the next capture. Busy and control-status effects are observed at the next scan.

// File: rtl/dmi_port_pkg.sv
package dmi_port_pkg;
  localparam logic [1:0] OP_NOP   = 2'd0;
  localparam logic [1:0] OP_READ  = 2'd1;
  localparam logic [1:0] OP_WRITE = 2'd2;
  localparam logic [1:0] ST_OK    = 2'd0;
  localparam logic [1:0] ST_FAIL  = 2'd2;
  localparam logic [1:0] ST_BUSY  = 2'd3;
  localparam logic [1:0] SEL_CTRL = 2'd1;
  localparam logic [1:0] SEL_ACC  = 2'd2;
  localparam int CTRL_LEN = 32;
  localparam int CLR_BUSY_BIT = 16;
  localparam int HARD_RST_BIT = 17;

  typedef struct packed {
    logic capCtrl;
    logic capAcc;
    logic capBusy;
    logic capByp;
    logic shift;
    logic accept;
    logic takeResp;
    logic hardReset;
  } dpStrobes_t;
endpackage

// File: rtl/dmi_port_ctrl.sv
module dmi_port_ctrl
  import dmi_port_pkg::*;
#(
  parameter int MIN_IDLE = 3,
  parameter int CW = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] drSel,
  input  logic       captureDr,
  input  logic       shiftDr,
  input  logic       updateDr,
  input  logic       rtiTick,
  input  logic [1:0] srOp,
  input  logic       srClrBusy,
  input  logic       srHardRst,
  input  logic       dmRespValid,
  output dpStrobes_t strb,
  output logic       busyQ
);
  logic [CW-1:0] idleLeft;
  logic          pendQ;
  logic          selCtrl, selAcc, owed, updCtrl, clrBusy, isReq;

  assign selCtrl = (drSel == SEL_CTRL);
  assign selAcc  = (drSel == SEL_ACC);
  assign owed    = (idleLeft != '0) || pendQ;
  assign updCtrl = updateDr && selCtrl;
  assign clrBusy = updCtrl && (srClrBusy || srHardRst);
  assign isReq   = (srOp == OP_READ) || (srOp == OP_WRITE);

  always_comb begin
    strb           = '0;
    strb.capCtrl   = captureDr && selCtrl;
    strb.capAcc    = captureDr && selAcc;
    strb.capBusy   = captureDr && selAcc && (owed || busyQ);
    strb.capByp    = captureDr && !selCtrl && !selAcc;
    strb.shift     = shiftDr;
    strb.accept    = updateDr && selAcc && !busyQ;
    strb.takeResp  = dmRespValid && pendQ;
    strb.hardReset = updCtrl && srHardRst;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ    <= 1'b0;
      idleLeft <= '0;
      pendQ    <= 1'b0;
    end else begin
      if (clrBusy) busyQ <= 1'b0;
      else if (strb.capBusy) busyQ <= 1'b1;

      if (strb.hardReset) idleLeft <= '0;
      else if (strb.accept) idleLeft <= CW'(MIN_IDLE);
      else if (rtiTick && idleLeft != '0) idleLeft <= idleLeft - 1'b1;

      if (strb.accept && isReq) pendQ <= 1'b1;
      else if (strb.takeResp) pendQ <= 1'b0;
    end
  end

  // R4: sticky until explicitly cleared
  p_busy_sticky_r4: assert property (@(posedge clk) disable iff (!rstN)
    busyQ && !clrBusy |=> busyQ);
  // R9: reload on acceptance
  p_idle_reload_r9: assert property (@(posedge clk) disable iff (!rstN)
    strb.accept && !strb.hardReset |=> idleLeft == CW'(MIN_IDLE));
  // R9: saturates at zero
  p_idle_floor_r9: assert property (@(posedge clk) disable iff (!rstN)
    idleLeft == '0 && !strb.accept |=> idleLeft == '0);
endmodule

// File: rtl/dmi_port_dp.sv
module dmi_port_dp
  import dmi_port_pkg::*;
#(
  parameter int ABITS = 7,
  parameter int AW = 41,
  parameter logic [3:0] VERSION = 4'd1,
  parameter logic [2:0] IDLE_HINT = 3'd3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       drSel,
  input  dpStrobes_t       strb,
  input  logic             busyQ,
  input  logic             tdi,
  input  logic [31:0]      dmRespData,
  input  logic             dmRespErr,
  output logic             tdo,
  output logic [1:0]       srOp,
  output logic             srClrBusy,
  output logic             srHardRst,
  output logic             dmReqValid,
  output logic             dmReqWrite,
  output logic [ABITS-1:0] dmReqAddr,
  output logic [31:0]      dmReqData
);
  logic [AW-1:0]    sr, srShifted;
  logic [ABITS-1:0] resAddr;
  logic [31:0]      resData;
  logic [1:0]       resOp;
  logic [31:0]      ctrlWord;
  logic             srIsReq;

  assign ctrlWord  = {17'd0, IDLE_HINT, (busyQ ? ST_BUSY : ST_OK),
                      6'(ABITS), VERSION};
  assign tdo       = sr[0];
  assign srOp      = sr[1:0];
  assign srClrBusy = sr[CLR_BUSY_BIT];
  assign srHardRst = sr[HARD_RST_BIT];
  assign srIsReq   = (sr[1:0] == OP_READ) || (sr[1:0] == OP_WRITE);

  always_comb begin
    srShifted = sr >> 1;
    case (drSel)
      SEL_CTRL: srShifted[CTRL_LEN-1] = tdi;
      SEL_ACC:  srShifted[AW-1] = tdi;
      default:  srShifted[0] = tdi;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sr <= '0;
    end else if (strb.capCtrl) begin
      sr <= AW'(ctrlWord);
    end else if (strb.capBusy) begin
      sr <= AW'(ST_BUSY);
    end else if (strb.capAcc) begin
      sr <= {resAddr, resData, resOp};
    end else if (strb.capByp) begin
      sr <= '0;
    end else if (strb.shift) begin
      sr <= srShifted;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resAddr <= '0;
      resData <= '0;
      resOp   <= ST_OK;
    end else if (strb.hardReset) begin
      resAddr <= '0;
      resData <= '0;
      resOp   <= ST_OK;
    end else if (strb.accept) begin
      resAddr <= sr[AW-1:34];
      resData <= sr[33:2];
      resOp   <= ST_OK;
    end else if (strb.takeResp) begin
      if (!dmReqWrite && !dmRespErr) resData <= dmRespData;
      resOp <= dmRespErr ? ST_FAIL : ST_OK;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dmReqValid <= 1'b0;
      dmReqWrite <= 1'b0;
      dmReqAddr  <= '0;
      dmReqData  <= '0;
    end else begin
      dmReqValid <= strb.accept && srIsReq;
      if (strb.accept) begin
        dmReqWrite <= (sr[1:0] == OP_WRITE);
        dmReqAddr  <= sr[AW-1:34];
        dmReqData  <= sr[33:2];
      end
    end
  end

  // R4: busy capture loads the busy code alone
  p_busy_word_r4: assert property (@(posedge clk) disable iff (!rstN)
    strb.capBusy |=> sr == AW'(ST_BUSY));
  // R10: stored result untouched without an accepted access or response
  p_result_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    !strb.accept && !strb.takeResp && !strb.hardReset
      |=> $stable({resAddr, resData, resOp}));
  // R7: request lasts one cycle
  p_req_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    dmReqValid |=> !dmReqValid);
endmodule

// File: rtl/dmi_access_port.sv
module dmi_access_port
  import dmi_port_pkg::*;
#(
  parameter int ABITS = 7,
  parameter int MIN_IDLE = 3,
  parameter logic [3:0] VERSION = 4'd1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       drSel,
  input  logic             captureDr,
  input  logic             shiftDr,
  input  logic             updateDr,
  input  logic             rtiTick,
  input  logic             tdi,
  output logic             tdo,
  output logic             dmReqValid,
  output logic             dmReqWrite,
  output logic [ABITS-1:0] dmReqAddr,
  output logic [31:0]      dmReqData,
  input  logic             dmRespValid,
  input  logic [31:0]      dmRespData,
  input  logic             dmRespErr
);
  localparam int AW = ABITS + 34;
  localparam int CW = (MIN_IDLE < 1) ? 1 : $clog2(MIN_IDLE + 1);
  localparam logic [2:0] IDLE_HINT = (MIN_IDLE > 7) ? 3'd7 : 3'(MIN_IDLE);

  dpStrobes_t strb;
  logic       busyQ, srClrBusy, srHardRst;
  logic [1:0] srOp;

  dmi_port_ctrl #(.MIN_IDLE(MIN_IDLE), .CW(CW)) uCtrl (
    .clk(clk), .rstN(rstN), .drSel(drSel), .captureDr(captureDr),
    .shiftDr(shiftDr), .updateDr(updateDr), .rtiTick(rtiTick),
    .srOp(srOp), .srClrBusy(srClrBusy), .srHardRst(srHardRst),
    .dmRespValid(dmRespValid), .strb(strb), .busyQ(busyQ)
  );

  dmi_port_dp #(.ABITS(ABITS), .AW(AW), .VERSION(VERSION),
                .IDLE_HINT(IDLE_HINT)) uDp (
    .clk(clk), .rstN(rstN), .drSel(drSel), .strb(strb), .busyQ(busyQ),
    .tdi(tdi), .dmRespData(dmRespData), .dmRespErr(dmRespErr), .tdo(tdo),
    .srOp(srOp), .srClrBusy(srClrBusy), .srHardRst(srHardRst),
    .dmReqValid(dmReqValid), .dmReqWrite(dmReqWrite),
    .dmReqAddr(dmReqAddr), .dmReqData(dmReqData)
  );
endmodule

// File: tb/tb_dmi_access_port.sv
module tb_dmi_access_port;
  localparam int ABITS = 7;
  localparam int AW = ABITS + 34;
  localparam logic [63:0] CTRL_IDLE = 64'h3071;
  localparam logic [63:0] CTRL_BUSY = 64'h3C71;

  logic clk = 0, rstN = 0;
  logic [1:0] drSel = 0;
  logic captureDr = 0, shiftDr = 0, updateDr = 0, rtiTick = 0, tdi = 0;
  logic tdo, dmReqValid, dmReqWrite;
  logic [ABITS-1:0] dmReqAddr;
  logic [31:0] dmReqData, dmRespData = 0;
  logic dmRespValid = 0, dmRespErr = 0;

  int checks = 0, errors = 0;
  logic [63:0] expQ[$];
  string tagQ[$];
  logic [39:0] reqQ[$];
  string reqTagQ[$];
  logic [63:0] capWord;
  event scanDone;
  bit done = 0;

  always #10 clk = ~clk;

  dmi_access_port dut (
    .clk(clk), .rstN(rstN), .drSel(drSel), .captureDr(captureDr),
    .shiftDr(shiftDr), .updateDr(updateDr), .rtiTick(rtiTick), .tdi(tdi),
    .tdo(tdo), .dmReqValid(dmReqValid), .dmReqWrite(dmReqWrite),
    .dmReqAddr(dmReqAddr), .dmReqData(dmReqData), .dmRespValid(dmRespValid),
    .dmRespData(dmRespData), .dmRespErr(dmRespErr)
  );

  task automatic check(string tag, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  function automatic logic [63:0] accWord(logic [6:0] a, logic [31:0] d, logic [1:0] op);
    return 64'({a, d, op});
  endfunction

  task automatic expectCap(logic [63:0] v, string tag);
    expQ.push_back(v);
    tagQ.push_back(tag);
  endtask

  task automatic expectReq(logic wr, logic [6:0] a, logic [31:0] d, string tag);
    reqQ.push_back({wr, a, d});
    reqTagQ.push_back(tag);
  endtask

  task automatic scan(logic [1:0] sel, int len, logic [63:0] inWord);
    @(negedge clk);
    drSel = sel;
    captureDr = 1;
    @(negedge clk);
    captureDr = 0;
    capWord = '0;
    for (int i = 0; i < len; i++) begin
      capWord[i] = tdo;
      tdi = inWord[i];
      shiftDr = 1;
      @(negedge clk);
    end
    shiftDr = 0;
    updateDr = 1;
    ->scanDone;
    @(negedge clk);
    updateDr = 0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rtiTick = 1;
    end
    @(negedge clk);
    rtiTick = 0;
    repeat (2) @(negedge clk);
  endtask

  // capture monitor
  initial forever begin
    @(scanDone);
    if (expQ.size() == 0) begin
      checks++; errors++;
      $display("FAIL R5 unexpected scan got=%h exp=none", capWord);
    end else begin
      string t;
      t = tagQ.pop_front();
      check(t, capWord, expQ.pop_front());
    end
  end

  // debug module responder and request monitor
  initial forever begin
    @(negedge clk);
    if (dmReqValid) begin
      logic [6:0] a;
      logic w;
      a = dmReqAddr;
      w = dmReqWrite;
      if (reqQ.size() == 0) begin
        checks++; errors++;
        $display("FAIL R10 unexpected request got=%h exp=none", {dmReqWrite, dmReqAddr, dmReqData});
      end else begin
        logic [39:0] e;
        string t;
        e = reqQ.pop_front();
        t = reqTagQ.pop_front();
        if (e[39]) check(t, 64'({dmReqWrite, dmReqAddr, dmReqData}), 64'(e));
        else check(t, 64'({dmReqWrite, dmReqAddr}), 64'(e[39:32]));
      end
      @(negedge clk);
      dmRespValid = 1;
      dmRespErr = (a == 7'h7F);
      dmRespData = w ? 32'h0 : (32'hA5A5_0000 | 32'(a));
      @(negedge clk);
      dmRespValid = 0;
      dmRespErr = 0;
    end
  end

  initial begin
    #(20 * 20000);
    checks++; errors++;
    $display("FAIL watchdog got=timeout exp=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R11 tdo after reset", 64'(tdo), 64'd0);
    rstN = 1;
    @(negedge clk);
    // R1 control layout at reset
    expectCap(CTRL_IDLE, "R1 control word idle");
    scan(2'd1, 32, 64'd0);
    // R11 bypass: captured 0 then tdi comes through
    expectCap(64'b10, "R11 bypass length one");
    scan(2'd0, 2, 64'b11);
    // R7 write, first capture returns reset result (R5)
    expectCap(64'd0, "R5 initial result");
    expectReq(1'b1, 7'h05, 32'h1234_5678, "R7 write request");
    scan(2'd2, AW, accWord(7'h05, 32'h1234_5678, 2'd2));
    idle(3);
    // R6 read; capture shows write result with success (R8)
    expectCap(accWord(7'h05, 32'h1234_5678, 2'd0), "R8 write success result");
    expectReq(1'b0, 7'h0C, 32'h0, "R6 read request");
    scan(2'd2, AW, accWord(7'h0C, 32'h0, 2'd1));
    idle(3);
    // R12 nop; capture shows read data (R6)
    expectCap(accWord(7'h0C, 32'hA5A5_000C, 2'd0), "R6 read data stored");
    scan(2'd2, AW, accWord(7'h09, 32'hDEAD_0001, 2'd0));
    // R4 too early -> busy; R10 write ignored
    expectCap(64'd3, "R4 busy when idle owed");
    scan(2'd2, AW, accWord(7'h03, 32'h0, 2'd2));
    idle(3);
    expectCap(64'd3, "R4 busy stays sticky");
    scan(2'd2, AW, accWord(7'h03, 32'h0, 2'd2));
    idle(3);
    // R1 status while busy, then clear via bit 16
    expectCap(CTRL_BUSY, "R1 control word busy status");
    scan(2'd1, 32, 64'h1_0000);
    expectCap(CTRL_IDLE, "R2 busy cleared");
    scan(2'd1, 32, 64'd0);
    // R2/R10/R12: result is the nop, unchanged by busy updates
    expectCap(accWord(7'h09, 32'hDEAD_0001, 2'd0), "R10 result kept through busy");
    expectReq(1'b0, 7'h7F, 32'h0, "R6 read to failing address");
    scan(2'd2, AW, accWord(7'h7F, 32'h0, 2'd1));
    idle(3);
    expectCap(accWord(7'h7F, 32'h0, 2'd2), "R8 failed status");
    scan(2'd2, AW, accWord(7'h01, 32'h0, 2'd0));
    idle(1);
    expectCap(64'd3, "R9 counter not yet expired");
    scan(2'd2, AW, accWord(7'h01, 32'h0, 2'd0));
    expectCap(CTRL_BUSY, "R1 busy before clear");
    scan(2'd1, 32, 64'h1_0000);
    idle(3);
    expectCap(accWord(7'h01, 32'h0, 2'd0), "R12 nop result");
    scan(2'd2, AW, accWord(7'h02, 32'h5, 2'd0));
    // R3 hard reset right after accepted access (counter owed)
    expectCap(CTRL_IDLE, "R3 control before hard reset");
    scan(2'd1, 32, 64'h2_0000);
    expectCap(64'd0, "R3 state cleared");
    scan(2'd2, AW, accWord(7'h00, 32'h0, 2'd0));
    idle(3);
    repeat (4) @(negedge clk);
    check("R5 all captures consumed", 64'(expQ.size()), 64'd0);
    check("R10 all requests seen", 64'(reqQ.size()), 64'd0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule